// File: doc/BRIEF.md
# NAND Flash Command Interface Decoder

This block is the device-side front end of a small byte-wide NAND flash memory. It watches the external write strobe and an 8-bit shared I/O bus, and sorts every completed write cycle into a command, an address byte or a data byte. Two strobe lines select the kind of cycle: a command-latch line and an address-latch line. The block follows the multi-cycle command sequences, builds a 19-bit byte address, and hands the back end single-cycle operation requests. Those requests are read, frame program, block erase, status read, read ID and reset. Program data bytes are passed straight through. The back end answers with a busy level, a done pulse and a pass/fail flag. While it is busy, the decoder honours only reset and status read.

The byte address is `{row[11:0], column[6:0]}`. The memory has 4096 rows, and a row holds 128 bytes. An erase block is 32 rows, so a block number is row bits [11:5]. The bus is taken to be synchronous to `clk`. A write cycle is recognised when `bus_we_n` has been sampled low and is then sampled high, with `bus_ce_n` low on both samples.

The sequencer has six states. `SQ_IDLE` waits for a command. The read-setup command moves it to `SQ_RD_ADDR`. After the third address byte it issues a read and returns to `SQ_IDLE`. The program-setup command moves it to `SQ_PG_ADDR`. After three address bytes it goes to `SQ_PG_DATA`, where data bytes are forwarded, and the program confirm issues the program and returns to `SQ_IDLE`. The erase-setup command moves it to `SQ_ER_ADDR`. After two row bytes it goes to `SQ_ER_CONF`, and the erase confirm issues the erase and returns to `SQ_IDLE`. A reset, a read ID, an undefined code or a misplaced confirm byte takes any state back to `SQ_IDLE`. A status read leaves the state unchanged.

Top module: `nand_cmd_front`

## Requirements
- R1: A write cycle is taken only when `bus_we_n` rises while `bus_ce_n` is low. The cycle is a command when the command-latch line alone is high, an address when the address-latch line alone is high, and data when both are low. A cycle with both lines high, or with `bus_ce_n` high, has no effect.
- R2: Command 00h followed by three address bytes issues one read request (`req_op`=1). The first byte gives the column in bits [6:0], and its bit 7 is dropped. The second byte gives row[7:0] and the third gives row[11:8] in its bits [3:0]. `req_addr` is `{row, column}`. The request appears at most two clocks after the closing write strobe and lasts one clock.
- R3: Command 80h followed by three address bytes (laid out as in R2) enters the data phase. There, each data cycle pulses `data_valid` with the byte on `data_byte`. Command 10h then issues a program request (`req_op`=2) carrying that address.
- R4: Command 60h followed by two address bytes, row[7:0] and then row[11:8], and then command D0h issues an erase request (`req_op`=3). `req_addr` holds row[11:5] in bits [18:12], and bits [11:0] are zero.
- R5: Command 70h issues a status request (`req_op`=4) and command 90h issues an ID request (`req_op`=5). Each is a single cycle.
- R6: A confirm byte (10h or D0h) that does not follow its own completed setup and address phase issues no request and returns the decoder to idle.
- R7: Any command code outside the defined set issues nothing and drops any partial sequence.
- R8: While `be_busy` is high, only FFh and 70h are acted on. Other commands, address bytes and data bytes are ignored and leave the sequence state untouched.
- R9: Command FFh issues a reset request (`req_op`=6) and returns the decoder to idle. If `be_busy` is high at that moment, `be_abort` pulses in the same clock as the request.
- R10: `status_byte` bit 6 is 1 when the back end is ready and 0 when it is busy. Bit 0 holds the `be_fail` value captured at the last `be_done` pulse, and an FFh command clears it to 0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write strobe, active low; the cycle completes on its rise |
| bus_cle | input | 1 | Command-latch line |
| bus_ale | input | 1 | Address-latch line |
| bus_io | input | 8 | Shared command/address/data byte |
| be_busy | input | 1 | Back end busy level |
| be_done | input | 1 | Back end completion pulse |
| be_fail | input | 1 | Back end fail flag, valid with `be_done` |
| req_valid | output | 1 | One-clock operation request |
| req_op | output | 3 | Operation code: 1 read, 2 program, 3 erase, 4 status, 5 ID, 6 reset |
| req_addr | output | 19 | Byte address for the request |
| data_valid | output | 1 | One-clock program data strobe |
| data_byte | output | 8 | Program data byte |
| be_abort | output | 1 | Abort pulse to a busy back end |
| status_byte | output | 8 | Status: bit 6 ready, bit 0 fail |

## Verification
Stale sequence state shows up at the ports as a missing or extra request. A lost state shows as a read or erase that never arrives after its final byte. A state that fails to clear shows as a request issued from bytes sent after an abort, a reset or a busy window. A wrong address counter shows as a misplaced column or row field in `req_addr`, visible on the same clock as the request. Each of these faults therefore shows within two clocks of the write strobe that should have finished, or should not have finished, a sequence.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADDR,
        CYC_DATA,
        CYC_NONE
    } cyc_kind_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_STATUS = 3'd4,
        OP_ID     = 3'd5,
        OP_RESET  = 3'd6
    } op_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_PG_ADDR,
        SQ_PG_DATA,
        SQ_ER_ADDR,
        SQ_ER_CONF
    } seq_state_t;

    localparam logic [7:0] CMD_READ        = 8'h00;
    localparam logic [7:0] CMD_RESET       = 8'hFF;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
    localparam logic [7:0] CMD_ID          = 8'h90;

    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_FAIL_BIT = 0;

endpackage

// File: rtl/nfc_bus_capture.sv
`timescale 1ns/1ps
module nfc_bus_capture
    import nfc_pkg::*;
#(
    parameter int IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    input  logic [IO_W-1:0] io,
    output logic            cyc_valid,
    output cyc_kind_t       cyc_kind,
    output logic [IO_W-1:0] cyc_byte
);

    logic            armed;
    logic            hold_cle;
    logic            hold_ale;
    logic [IO_W-1:0] hold_io;

    // Hold the bus while the strobe is low; fire once when it rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            cyc_valid <= 1'b0;
            hold_cle  <= 1'b0;
            hold_ale  <= 1'b0;
            hold_io   <= '0;
        end else begin
            cyc_valid <= 1'b0;
            if (ce_n) begin
                armed <= 1'b0;
            end else if (!we_n) begin
                armed    <= 1'b1;
                hold_cle <= cle;
                hold_ale <= ale;
                hold_io  <= io;
            end else if (armed) begin
                armed     <= 1'b0;
                cyc_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case ({hold_cle, hold_ale})
            2'b10:   cyc_kind = CYC_CMD;
            2'b01:   cyc_kind = CYC_ADDR;
            2'b00:   cyc_kind = CYC_DATA;
            default: cyc_kind = CYC_NONE;
        endcase
    end

    assign cyc_byte = hold_io;

endmodule

// File: rtl/nfc_seq_fsm.sv
`timescale 1ns/1ps
module nfc_seq_fsm
    import nfc_pkg::*;
#(
    parameter int IO_W         = 8,
    parameter int COL_W        = 7,
    parameter int ROW_W        = 12,
    parameter int BLK_ROW_BITS = 5,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int ROW_HI_W    = ROW_W - IO_W,
    localparam int BLK_ZERO_W  = BLK_ROW_BITS + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  cyc_kind_t         cyc_kind,
    input  logic [IO_W-1:0]   cyc_byte,
    input  logic              be_busy,
    output logic              req_valid,
    output op_t               req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic              data_valid,
    output logic [IO_W-1:0]   data_byte,
    output logic              be_abort,
    output logic              clr_fail
);

    seq_state_t       state, nxt;
    logic [1:0]       acnt;
    logic [1:0]       slot;
    logic [COL_W-1:0] col_q, col_n;
    logic [ROW_W-1:0] row_q, row_n;
    op_t              act_op;
    logic             act_data;
    logic             act_abort;
    logic             addr_take;
    logic             seq_restart;

    // Next state and the action chosen for this cycle.
    always_comb begin
        nxt         = state;
        act_op      = OP_NONE;
        act_data    = 1'b0;
        act_abort   = 1'b0;
        addr_take   = 1'b0;
        seq_restart = 1'b0;
        if (cyc_valid) begin
            unique case (cyc_kind)
                CYC_CMD: begin
                    if (cyc_byte == CMD_RESET) begin
                        nxt         = SQ_IDLE;
                        act_op      = OP_RESET;
                        act_abort   = be_busy;
                        seq_restart = 1'b1;
                    end else if (cyc_byte == CMD_STATUS) begin
                        act_op = OP_STATUS;
                    end else if (!be_busy) begin
                        seq_restart = 1'b1;
                        case (cyc_byte)
                            CMD_READ:        nxt = SQ_RD_ADDR;
                            CMD_PROG_SETUP:  nxt = SQ_PG_ADDR;
                            CMD_ERASE_SETUP: nxt = SQ_ER_ADDR;
                            CMD_ID: begin
                                nxt    = SQ_IDLE;
                                act_op = OP_ID;
                            end
                            CMD_PROG_GO: begin
                                nxt = SQ_IDLE;
                                if (state == SQ_PG_DATA) act_op = OP_PROG;
                            end
                            CMD_ERASE_GO: begin
                                nxt = SQ_IDLE;
                                if (state == SQ_ER_CONF) act_op = OP_ERASE;
                            end
                            default: nxt = SQ_IDLE;
                        endcase
                    end
                end
                CYC_ADDR: begin
                    if (!be_busy) begin
                        unique case (state)
                            SQ_RD_ADDR: begin
                                addr_take = 1'b1;
                                if (acnt == 2'd2) begin
                                    nxt    = SQ_IDLE;
                                    act_op = OP_READ;
                                end
                            end
                            SQ_PG_ADDR: begin
                                addr_take = 1'b1;
                                if (acnt == 2'd2) nxt = SQ_PG_DATA;
                            end
                            SQ_ER_ADDR: begin
                                addr_take = 1'b1;
                                if (acnt == 2'd1) nxt = SQ_ER_CONF;
                            end
                            default: ;
                        endcase
                    end
                end
                CYC_DATA: begin
                    if (!be_busy && state == SQ_PG_DATA) act_data = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Erase skips the column byte, so its first byte lands in slot 1.
    assign slot = (state == SQ_ER_ADDR) ? acnt + 2'd1 : acnt;

    always_comb begin
        col_n = col_q;
        row_n = row_q;
        if (addr_take) begin
            case (slot)
                2'd0:    col_n = cyc_byte[COL_W-1:0];
                2'd1:    row_n[IO_W-1:0] = cyc_byte;
                2'd2:    row_n[ROW_W-1:IO_W] = cyc_byte[ROW_HI_W-1:0];
                default: ;
            endcase
        end
    end

    // State register and sequence bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            acnt  <= 2'd0;
            col_q <= '0;
            row_q <= '0;
        end else begin
            state <= nxt;
            col_q <= col_n;
            row_q <= row_n;
            if (seq_restart || nxt != state) acnt <= 2'd0;
            else if (addr_take)              acnt <= acnt + 2'd1;
        end
    end

    // Registered outputs to the back end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_op     <= OP_NONE;
            req_addr   <= '0;
            data_valid <= 1'b0;
            data_byte  <= '0;
            be_abort   <= 1'b0;
            clr_fail   <= 1'b0;
        end else begin
            req_valid  <= (act_op != OP_NONE);
            req_op     <= act_op;
            if (act_op == OP_ERASE)
                req_addr <= {row_n[ROW_W-1:BLK_ROW_BITS], {BLK_ZERO_W{1'b0}}};
            else
                req_addr <= {row_n, col_n};
            data_valid <= act_data;
            data_byte  <= cyc_byte;
            be_abort   <= act_abort;
            clr_fail   <= (act_op == OP_RESET);
        end
    end

endmodule

// File: rtl/nfc_status_reg.sv
`timescale 1ns/1ps
module nfc_status_reg
    import nfc_pkg::*;
#(
    parameter int IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            be_busy,
    input  logic            be_done,
    input  logic            be_fail,
    input  logic            clr_fail,
    output logic [IO_W-1:0] status_byte
);

    logic fail_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        fail_q <= 1'b0;
        else if (clr_fail) fail_q <= 1'b0;
        else if (be_done)  fail_q <= be_fail;
    end

    always_comb begin
        status_byte                = '0;
        status_byte[STAT_RDY_BIT]  = !be_busy;
        status_byte[STAT_FAIL_BIT] = fail_q;
    end

endmodule

// File: rtl/nand_cmd_front.sv
`timescale 1ns/1ps
module nand_cmd_front
    import nfc_pkg::*;
#(
    parameter int IO_W         = 8,
    parameter int COL_W        = 7,
    parameter int ROW_W        = 12,
    parameter int BLK_ROW_BITS = 5,
    localparam int ADDR_W      = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_cle,
    input  logic              bus_ale,
    input  logic [IO_W-1:0]   bus_io,
    input  logic              be_busy,
    input  logic              be_done,
    input  logic              be_fail,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic              data_valid,
    output logic [IO_W-1:0]   data_byte,
    output logic              be_abort,
    output logic [IO_W-1:0]   status_byte
);

    logic            cyc_valid;
    cyc_kind_t       cyc_kind;
    logic [IO_W-1:0] cyc_byte;
    op_t             op_q;
    logic            clr_fail;

    nfc_bus_capture #(.IO_W(IO_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (bus_ce_n),
        .we_n      (bus_we_n),
        .cle       (bus_cle),
        .ale       (bus_ale),
        .io        (bus_io),
        .cyc_valid (cyc_valid),
        .cyc_kind  (cyc_kind),
        .cyc_byte  (cyc_byte)
    );

    nfc_seq_fsm #(
        .IO_W         (IO_W),
        .COL_W        (COL_W),
        .ROW_W        (ROW_W),
        .BLK_ROW_BITS (BLK_ROW_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_valid  (cyc_valid),
        .cyc_kind   (cyc_kind),
        .cyc_byte   (cyc_byte),
        .be_busy    (be_busy),
        .req_valid  (req_valid),
        .req_op     (op_q),
        .req_addr   (req_addr),
        .data_valid (data_valid),
        .data_byte  (data_byte),
        .be_abort   (be_abort),
        .clr_fail   (clr_fail)
    );

    nfc_status_reg #(.IO_W(IO_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .be_busy     (be_busy),
        .be_done     (be_done),
        .be_fail     (be_fail),
        .clr_fail    (clr_fail),
        .status_byte (status_byte)
    );

    assign req_op = op_q;

endmodule

// File: rtl/nand_cmd_front_chk.sv
`timescale 1ns/1ps
module nand_cmd_front_chk #(
    parameter int LOW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             be_busy,
    input logic             be_done,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [LOW_W-1:0] addr_low,
    input logic             data_valid,
    input logic             be_abort,
    input logic             fail_bit
);

    // R2: requests are single-cycle pulses
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R1: a write cycle yields at most one kind of output event
    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && data_valid));

    // R8: a decision taken while busy may only be status or reset
    a_r8_busy_whitelist: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(be_busy)) |-> (req_op == 3'd4 || req_op == 3'd6));

    // R9: abort only accompanies a reset request
    a_r9_abort_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        be_abort |-> (req_valid && req_op == 3'd6));

    // R4: erase addresses are block aligned
    a_r4_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |-> (addr_low == '0));

    // R10: the fail flag moves only after a done pulse or a reset request
    a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(be_done) && !($past(req_valid) && $past(req_op) == 3'd6))
            |-> $stable(fail_bit));

endmodule

bind nand_cmd_front nand_cmd_front_chk #(.LOW_W(BLK_ROW_BITS + COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .be_busy    (be_busy),
    .be_done    (be_done),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .addr_low   (req_addr[BLK_ROW_BITS+COL_W-1:0]),
    .data_valid (data_valid),
    .be_abort   (be_abort),
    .fail_bit   (status_byte[0])
);

// File: tb/nand_cmd_front_bench.sv
`timescale 1ns/1ps
module nand_cmd_front_bench;

    typedef struct {
        int    kind;     // 1 request, 2 data, 3 abort
        int    op;
        int    payload;  // negative: not compared
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_cle = 1'b0, bus_ale = 1'b0;
    logic [7:0]  bus_io = 8'h00;
    logic        be_busy = 1'b0, be_done = 1'b0, be_fail = 1'b0;
    logic        req_valid, data_valid, be_abort;
    logic [2:0]  req_op;
    logic [18:0] req_addr;
    logic [7:0]  data_byte, status_byte;

    int    tests = 0;
    int    fails = 0;
    string cur_tag = "R1";
    exp_t  q[$];

    always #2 clk = ~clk;

    nand_cmd_front u_nand_cmd_front (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
        .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_io(bus_io),
        .be_busy(be_busy), .be_done(be_done), .be_fail(be_fail),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .data_valid(data_valid), .data_byte(data_byte),
        .be_abort(be_abort), .status_byte(status_byte)
    );

    task automatic expect_ev(input int kind, input int op, input int payload, input string tag);
        exp_t e;
        e.kind = kind; e.op = op; e.payload = payload; e.tag = tag;
        q.push_back(e);
    endtask

    // kind: 0 command, 1 address, 2 data, 3 both latch lines high
    task automatic wr(input int kind, input logic [7:0] b, input logic ce_n = 1'b0);
        @(negedge clk);
        bus_ce_n = ce_n;
        bus_cle  = (kind == 0 || kind == 3);
        bus_ale  = (kind == 1 || kind == 3);
        bus_io   = b;
        bus_we_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_cle  = 1'b0;
        bus_ale  = 1'b0;
        bus_ce_n = 1'b1;
    endtask

    task automatic take(input int kind, input int op, input int pay);
        exp_t e;
        tests++;
        if (q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected event: actual kind=%0d op=%0d val=%h expected none",
                     cur_tag, kind, op, pay);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.op != op || (e.payload >= 0 && e.payload != pay)) begin
                fails++;
                $display("FAIL %s event: actual kind=%0d op=%0d val=%h expected kind=%0d op=%0d val=%h",
                         e.tag, kind, op, pay, e.kind, e.op, e.payload);
            end
        end
    endtask

    // Monitor: compare produced events against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (be_abort)   take(3, 0, 0);
            if (req_valid)  take(1, int'(req_op), int'(req_addr));
            if (data_valid) take(2, 0, int'(data_byte));
        end
    end

    task automatic check_quiet(input string tag);
        repeat (4) @(negedge clk);
        tests++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL %s missing events: actual pending=%0d expected 0", tag, q.size());
            q.delete();
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s value: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic done_pulse(input logic f);
        @(negedge clk); be_done = 1'b1; be_fail = f;
        @(negedge clk); be_done = 1'b0; be_fail = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state: ready, pass, no events
        check_val("R10 reset status", int'(status_byte), 8'h40);
        check_val("R2 reset req_valid", int'(req_valid), 0);

        // R2 read, column bit 7 dropped
        cur_tag = "R2";
        expect_ev(1, 1, int'({12'hBA3, 7'h55}), "R2 read");
        wr(0, 8'h00); wr(1, 8'hD5); wr(1, 8'hA3); wr(1, 8'hFB);
        check_quiet("R2");

        // R3 program with two data bytes
        cur_tag = "R3";
        wr(0, 8'h80); wr(1, 8'h12); wr(1, 8'h34); wr(1, 8'h05);
        expect_ev(2, 0, 8'hA5, "R3 data0"); wr(2, 8'hA5);
        expect_ev(2, 0, 8'h3C, "R3 data1"); wr(2, 8'h3C);
        expect_ev(1, 2, int'({12'h534, 7'h12}), "R3 program");
        wr(0, 8'h10);
        check_quiet("R3");

        // R4 erase, block = row[11:5]
        cur_tag = "R4";
        wr(0, 8'h60); wr(1, 8'hE7); wr(1, 8'h09);
        expect_ev(1, 3, int'({7'h4F, 12'h000}), "R4 erase");
        wr(0, 8'hD0);
        check_quiet("R4");

        // R5 single-cycle commands
        cur_tag = "R5";
        expect_ev(1, 4, -1, "R5 status"); wr(0, 8'h70);
        expect_ev(1, 5, -1, "R5 id");     wr(0, 8'h90);
        check_quiet("R5");

        // R6 misplaced confirms
        cur_tag = "R6";
        wr(0, 8'h10); wr(2, 8'h11);
        wr(0, 8'h60); wr(1, 8'h01); wr(1, 8'h02); wr(0, 8'h10); wr(0, 8'hD0);
        wr(0, 8'h80); wr(1, 8'h01); wr(1, 8'h02); wr(1, 8'h03); wr(0, 8'hD0);
        wr(0, 8'h10); wr(2, 8'h22);
        check_quiet("R6");

        // R7 undefined code drops a partial read
        cur_tag = "R7";
        wr(0, 8'h00); wr(1, 8'h01); wr(0, 8'h33); wr(1, 8'h02); wr(1, 8'h03);
        check_quiet("R7");

        // R1 ignored cycles: chip disabled, both latch lines high, idle data
        cur_tag = "R1";
        wr(0, 8'h90, 1'b1); wr(3, 8'h90); wr(2, 8'h44);
        check_quiet("R1");

        // R8 busy gating, partial read survives the busy window
        cur_tag = "R8";
        wr(0, 8'h00); wr(1, 8'h01);
        @(negedge clk); be_busy = 1'b1;
        @(negedge clk);
        check_val("R10 busy status", int'(status_byte), 8'h00);
        wr(1, 8'h77); wr(1, 8'h77); wr(0, 8'h90); wr(2, 8'h55);
        check_quiet("R8 ignored while busy");
        @(negedge clk); be_busy = 1'b0;
        expect_ev(1, 1, int'({12'h322, 7'h01}), "R8 read resumed");
        wr(1, 8'h22); wr(1, 8'h03);
        check_quiet("R8");
        @(negedge clk); be_busy = 1'b1;
        expect_ev(1, 4, -1, "R8 status while busy"); wr(0, 8'h70);
        // R9 reset while busy: abort and reset request together
        cur_tag = "R9";
        expect_ev(3, 0, 0, "R9 abort");
        expect_ev(1, 6, -1, "R9 reset busy");
        wr(0, 8'hFF);
        check_quiet("R9 busy");
        @(negedge clk); be_busy = 1'b0;

        // R9 reset mid-sequence while ready: no abort, sequence dropped
        wr(0, 8'h80); wr(1, 8'h05);
        expect_ev(1, 6, -1, "R9 reset idle"); wr(0, 8'hFF);
        wr(1, 8'h06); wr(1, 8'h07); wr(2, 8'h08);
        check_quiet("R9");

        // R10 fail flag capture and clear
        cur_tag = "R10";
        done_pulse(1'b1);
        check_val("R10 fail set", int'(status_byte), 8'h41);
        done_pulse(1'b0);
        check_val("R10 pass", int'(status_byte), 8'h40);
        done_pulse(1'b1);
        expect_ev(1, 6, -1, "R10 reset clears"); wr(0, 8'hFF);
        check_val("R10 fail cleared", int'(status_byte), 8'h40);
        check_quiet("R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule